// File: doc/BRIEF.md
# Audio Sample Write Packer

This block sits between a byte-addressable register write port and the push side of an audio sample FIFO. Software writes a sample into a four-byte data window, one byte at a time, in halves, or in a single 32-bit access. Each write carries byte enables that select lanes 0 to 3 of a lane-aligned 32-bit data bus. The block merges the enabled bytes into a staging word. A selectable sample length decides which lanes belong to a sample.

A FIFO push fires only when a write touches the most significant lane that the selected length uses. The pushed word holds the staged bytes plus the bytes of that write. Lanes above the length are forced to zero. Any lane that was not written since the last push also reads as zero. After every push the staging word is emptied, so the next sample starts again at lane 0. A write that touches only unused lanes is ignored. If the FIFO is full when a push fires, the sample is dropped and a sticky overflow flag is raised.

Top module: `audio_wr_packer`

## Requirements
- R1: `len_mode` selects the sample length and the lanes it uses. 0 selects 16-bit, lanes 0-1, top lane 1. 1 selects 20-bit, lanes 0-2, top lane 2. 2 selects 24-bit, lanes 0-2, top lane 2. 3 selects 32-bit, lanes 0-3, top lane 3. Lane n is `wr_data[8n+7:8n]`, enabled by `wr_be[n]`.
- R2: A write whose enables include the top lane makes `fifo_push` high for exactly the next cycle.
- R3: Writes that touch used lanes but not the top lane store their bytes and cause no push. Their bytes appear in the next pushed word.
- R4: Bytes in lanes above the selected length are discarded, and those bit positions of `fifo_wdata` are zero.
- R5: A write that touches only unused lanes causes no push and does not change the staged bytes.
- R6: With the 20-bit length, bits 23:20 of the pushed word are zero.
- R7: The staging word is emptied after each push. Lanes not written since the previous push are zero in the pushed word.
- R8: `fifo_wide` is 0 with a push in 16-bit mode, where the entry is `fifo_wdata[15:0]` and bits 31:16 are zero. It is 1 with a push in every other mode.
- R9: When `fifo_full` is high in the cycle a push would fire, no push occurs. The staging word is still emptied, and `overflow` goes high the next cycle and stays high until reset.
- R10: After reset, `fifo_push` and `overflow` are 0 and the staging word is empty.
- R11: A single write with all used lanes enabled pushes the complete sample in one transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_mode | input | 2 | Sample length select (R1) |
| wr_en | input | 1 | Write strobe into the data window |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Lane-aligned write data |
| fifo_full | input | 1 | FIFO cannot accept a push |
| fifo_push | output | 1 | One-cycle push strobe |
| fifo_wdata | output | 32 | Assembled sample |
| fifo_wide | output | 1 | Entry is 32 bits (1) or 16 bits (0) |
| overflow | output | 1 | Sticky drop indicator |

## Verification
The block has no parameters, so the bench builds its single fixed configuration. That configuration exercises all four length codes, covering 2, 3 and 4 used lanes and the nibble mask. The bench also switches the length code between samples, which shows that staging is emptied across a mode change. The FIFO-full input is driven directly, so drop and overflow behaviour is reachable without any FIFO model.

// File: rtl/audio_wr_packer.sv
module audio_wr_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  len_mode,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        fifo_full,
  output logic        fifo_push,
  output logic [31:0] fifo_wdata,
  output logic        fifo_wide,
  output logic        overflow
);

  logic [1:0]  top_lane;
  logic [3:0]  used, eff_be;
  logic [31:0] stage, merged, keep, word;
  logic        fire;

  always_comb begin
    case (len_mode)
      2'd0:    begin top_lane = 2'd1; keep = 32'h0000_FFFF; end
      2'd1:    begin top_lane = 2'd2; keep = 32'h000F_FFFF; end
      2'd2:    begin top_lane = 2'd2; keep = 32'h00FF_FFFF; end
      default: begin top_lane = 2'd3; keep = 32'hFFFF_FFFF; end
    endcase
  end

  assign used   = 4'b1111 >> (2'd3 - top_lane);
  assign eff_be = wr_en ? (wr_be & used) : 4'b0000;
  assign fire   = eff_be[top_lane];

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign merged[8*i +: 8] = eff_be[i] ? wr_data[8*i +: 8] : stage[8*i +: 8];
  end

  assign word = merged & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= '0;
      fifo_push  <= 1'b0;
      fifo_wdata <= '0;
      fifo_wide  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      fifo_push <= fire && !fifo_full;
      if (fire) begin
        stage <= '0;
        if (fifo_full) begin
          overflow <= 1'b1;
        end else begin
          fifo_wdata <= word;
          fifo_wide  <= (len_mode != 2'd0);
        end
      end else if (|eff_be) begin
        stage <= merged;
      end
    end
  end

  AST_PUSH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $past(wr_en)); // R2
  AST_TOP_WRITE_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_be[3] && len_mode == 2'd3 && !fifo_full |=> fifo_push); // R2
  AST_UNUSED_LANE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && len_mode == 2'd2 && wr_be == 4'b1000 |=> !fifo_push && $stable(stage)); // R5
  AST_NIBBLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push && $past(len_mode) == 2'd1 |-> fifo_wdata[31:20] == 12'h000); // R6
  AST_NARROW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push && !fifo_wide |-> fifo_wdata[31:16] == 16'h0000); // R8
  AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_be[3] && len_mode == 2'd3 && fifo_full |=> !fifo_push && overflow); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9

endmodule

// File: tb/tb_audio_wr_packer.sv
module tb_audio_wr_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  len_mode = 2'd0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic        fifo_full = 1'b0;
  logic        fifo_push, fifo_wide, overflow;
  logic [31:0] fifo_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  audio_wr_packer dut (
    .clk(clk), .rst_n(rst_n), .len_mode(len_mode), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .fifo_full(fifo_full),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .fifo_wide(fifo_wide), .overflow(overflow)
  );

  // {mode, be, data, exp_push, exp_wide, exp_word}
  localparam int NV = 14;
  localparam logic [71:0] VEC [NV] = '{
    {2'd2, 4'b0001, 32'h0000_00AA, 1'b0, 1'b0, 32'h0},          // R3 lane 0
    {2'd2, 4'b0010, 32'h0000_BB00, 1'b0, 1'b0, 32'h0},          // R3 lane 1
    {2'd2, 4'b0100, 32'h00CC_0000, 1'b1, 1'b1, 32'h00CC_BBAA},  // R1 R2 push on lane 2
    {2'd2, 4'b1000, 32'hDD00_0000, 1'b0, 1'b0, 32'h0},          // R5 unused lane only
    {2'd2, 4'b0100, 32'h0011_0000, 1'b1, 1'b1, 32'h0011_0000},  // R5 R7 stage emptied
    {2'd3, 4'b1111, 32'h1234_5678, 1'b1, 1'b1, 32'h1234_5678},  // R11 full word
    {2'd3, 4'b0011, 32'h0000_BEEF, 1'b0, 1'b0, 32'h0},          // R3 half
    {2'd3, 4'b1100, 32'hCAFE_0000, 1'b1, 1'b1, 32'hCAFE_BEEF},  // R2 upper half
    {2'd1, 4'b0111, 32'h00FF_FFFF, 1'b1, 1'b1, 32'h000F_FFFF},  // R6 nibble mask
    {2'd0, 4'b1111, 32'hAABB_CCDD, 1'b1, 1'b0, 32'h0000_CCDD},  // R4 R8 narrow entry
    {2'd0, 4'b1100, 32'h5566_0000, 1'b0, 1'b0, 32'h0},          // R5 16-bit unused lanes
    {2'd0, 4'b0010, 32'h0000_7700, 1'b1, 1'b0, 32'h0000_7700},  // R7 lane 0 zero
    {2'd1, 4'b0001, 32'h0000_00F1, 1'b0, 1'b0, 32'h0},          // R3 20-bit lane 0
    {2'd1, 4'b0100, 32'h00AB_0000, 1'b1, 1'b1, 32'h000B_00F1}   // R6 R7 lane 1 zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [3:0] be, input logic [31:0] d);
    len_mode = m; wr_be = be; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 push after reset", {31'h0, fifo_push}, 32'h0);
    chk("R10 overflow after reset", {31'h0, overflow}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:70], VEC[i][69:66], VEC[i][65:34]);
      chk($sformatf("R2 push vec %0d", i), {31'h0, fifo_push}, {31'h0, VEC[i][33]});
      if (VEC[i][33]) begin
        chk($sformatf("R4 word vec %0d", i), fifo_wdata, VEC[i][31:0]);
        chk($sformatf("R8 wide vec %0d", i), {31'h0, fifo_wide}, {31'h0, VEC[i][32]});
      end
      @(negedge clk);
      chk($sformatf("R2 single pulse vec %0d", i), {31'h0, fifo_push}, 32'h0);
    end

    // R10: staging empty after reset
    wr(2'd3, 4'b0001, 32'h0000_0042);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    wr(2'd3, 4'b1000, 32'h9900_0000);
    chk("R10 stage empty after reset", fifo_wdata, 32'h9900_0000);

    // R9: drop on full, stage emptied, sticky flag
    fifo_full = 1'b1;
    wr(2'd3, 4'b0001, 32'h0000_0033);
    chk("R9 no overflow before drop", {31'h0, overflow}, 32'h0);
    wr(2'd3, 4'b1110, 32'h7766_5500);
    chk("R9 no push when full", {31'h0, fifo_push}, 32'h0);
    chk("R9 overflow set", {31'h0, overflow}, 32'h1);
    fifo_full = 1'b0;
    wr(2'd3, 4'b1000, 32'h8000_0000);
    chk("R9 push after drop", {31'h0, fifo_push}, 32'h1);
    chk("R9 stage emptied on drop", fifo_wdata, 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk("R9 overflow sticky", {31'h0, overflow}, 32'h1);

    // R1: 32-bit mode lane 2 does not push
    wr(2'd3, 4'b0100, 32'h0044_0000);
    chk("R1 lane 2 not top in 32-bit", {31'h0, fifo_push}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule